// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital control half of a 10-bit successive-approximation converter that reads one of 16 analog inputs. Software reaches it through a small register window. It can set an enable bit, a channel number, a reference choice for each rail, an acquisition delay counted in conversion-clock periods (TAD) and a divider that derives TAD from the system clock. Setting the go bit starts the work: the block drives the channel select and reference selects, waits out the acquisition delay, holds the sample and runs ten bit trials. Each trial presents a trial code to an external DAC and reads back one comparator bit.

When the last trial is resolved, three things happen on the same clock edge. The 10-bit result lands in a high/low register pair, the go bit drops and a sticky interrupt flag rises. The sequencer then holds off for two TAD before another acquisition may begin. A go request issued inside that hold-off is remembered and starts as soon as the hold-off ends. Clearing the enable bit, or asserting reset, abandons any conversion in progress.

Top module: `sar_seq`

## Requirements
- R1: Reset clears enable, go, channel, divider, acquisition, both reference selects and the interrupt flag. It returns the sequencer to idle, abandoning any conversion in progress.
- R2: The result register pair has no reset, so a reset leaves the last result readable unchanged.
- R3: Trials run from bit 9 down to bit 0. The trial code is the bits already kept OR the bit under test. A bit is kept when cmp_in is 1 (input at or above the trial code), so the result is the largest accepted code, 0x000 to 0x3FF.
- R4: The divider code gives a TAD of 2, 4, 8, 16, 32 or 64 system clocks for codes 0 to 5. Codes 6 and 7 also give 64.
- R5: Acquisition codes 0 to 7 select 0, 2, 4, 6, 8, 12, 16 or 20 TAD. With TAD of N clocks and acquisition of A TAD, completion occurs N*(A+11) clocks after the edge that accepted go: A+1 TAD of acquisition, ending on the next TAD edge, followed by 10 trials.
- R6: On completion the result pair is written, go clears and the interrupt flag sets, all on one edge.
- R7: Two TAD elapse after completion before a new acquisition. A go written during that gap sets the go bit at once, and its acquisition begins when the gap ends.
- R8: The interrupt flag stays set until a write to address 3 with bit 7 at 0. A write with bit 7 at 1 has no effect, and a completion on the same edge as a clear wins.
- R9: A write to address 0 with go=1 and enable=0 is ignored, and go stays 0.
- R10: Channel and reference writes made during a conversion show in the register readback at once. mux_sel, vref_pos_ext and vref_neg_ext change only at the next acquisition start.
- R11: A write to address 0 with enable=0 during a conversion clears go and returns to idle. The interrupt flag is not set and the result is not written.
- R12: Register map for wr_sel/rd_sel:
  - Address 0 holds {2'b0, channel[3:0], go, enable}.
  - Address 1 holds {negative-rail external, positive-rail external, acq[2:0], div[2:0]}.
  - Address 2 reads result[7:0].
  - Address 3 reads {flag, 5'b0, result[9:8]}.
- R13: hold_o is high exactly during the ten trial TADs. trial_code is non-zero during them and zero at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Register address for the write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register address for the combinational read |
| rd_data | output | 8 | Read data of the register at rd_sel |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above trial_code |
| irq_o | output | 1 | Sticky conversion-complete flag |
| mux_sel | output | 4 | Applied analog channel select |
| vref_pos_ext | output | 1 | Applied positive reference: 1 selects the external pin |
| vref_neg_ext | output | 1 | Applied negative reference: 1 selects the external pin |
| hold_o | output | 1 | Sample held, trials running |
| trial_code | output | 10 | Code presented to the DAC during a trial |

## Verification
The assertions assume cmp_in settles within one system clock of trial_code and stays a fixed function of that code for the whole conversion. They also assume every write is a single-cycle strobe. The bench meets both conditions in the same way. It derives cmp_in combinationally by comparing trial_code with a per-channel input value held in an array indexed by mux_sel. It changes that array only while the sequencer is idle, and it drives each write for exactly one clock.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_CONV = 2'd2,
        ST_GAP  = 2'd3
    } sar_state_e;

    localparam int ACQ_MAX_TAD = 20;
    localparam int TAD_MAX_CLK = 64;

    // system clocks per TAD for a divider code
    function automatic int tad_period(input logic [2:0] code);
        if (code > 3'd5) return TAD_MAX_CLK;
        return 2 << code;
    endfunction

    // acquisition length in TAD for an acquisition code
    function automatic int acq_tads(input logic [2:0] code);
        case (code)
            3'd0: return 0;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 6;
            3'd4: return 8;
            3'd5: return 12;
            3'd6: return 16;
            default: return ACQ_MAX_TAD;
        endcase
    endfunction

endpackage

// File: rtl/sar_tad_gen.sv
module sar_tad_gen
    import sar_seq_pkg::*;
#(
    parameter int CNT_W = $clog2(TAD_MAX_CLK)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] div_code,
    output logic       tick
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    int               period;

    always_comb begin
        period = tad_period(div_code);
        tick   = run && (cnt_q == CNT_W'(period - 1));
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         cmp,
    output logic [W-1:0] trial,
    output logic         last,
    output logic [W-1:0] final_code
);
    typedef struct packed {
        logic [W-1:0] acc;
        logic [W-1:0] mask;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        if (load) begin
            eng_d.acc  = '0;
            eng_d.mask = {1'b1, {(W-1){1'b0}}};
        end else if (step) begin
            if (cmp) eng_d.acc = eng_q.acc | eng_q.mask;
            eng_d.mask = eng_q.mask >> 1;
        end
        trial      = eng_q.acc | eng_q.mask;
        last       = eng_q.mask[0];
        final_code = eng_q.acc | (cmp ? eng_q.mask : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_W   = 10,
    parameter int CH_W    = 4,
    parameter int GAP_TAD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [7:0]       wr_data,
    input  logic [1:0]       rd_sel,
    output logic [7:0]       rd_data,
    input  logic             cmp_in,
    output logic             irq_o,
    output logic [CH_W-1:0]  mux_sel,
    output logic             vref_pos_ext,
    output logic             vref_neg_ext,
    output logic             hold_o,
    output logic [RES_W-1:0] trial_code
);
    localparam int WAIT_W = $clog2(ACQ_MAX_TAD + 1);
    localparam int HI_W   = RES_W - 8;

    typedef struct packed {
        sar_state_e        state;
        logic              en;
        logic              go;
        logic [CH_W-1:0]   chan;
        logic [2:0]        div;
        logic [2:0]        acq;
        logic              pos;
        logic              neg;
        logic              irq;
        logic [CH_W-1:0]   chan_a;
        logic [2:0]        div_a;
        logic              pos_a;
        logic              neg_a;
        logic [WAIT_W-1:0] wait_n;
    } seq_t;

    seq_t             cs, nx;
    logic [RES_W-1:0] res_d, res_q;
    logic             res_we;
    logic             tick, load, step, last, go_req, abort, start;
    logic [RES_W-1:0] trial, final_code;

    sar_tad_gen u_tad (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (cs.state != ST_IDLE),
        .div_code (cs.div_a),
        .tick     (tick)
    );

    sar_bit_engine #(.W(RES_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .cmp        (cmp_in),
        .trial      (trial),
        .last       (last),
        .final_code (final_code)
    );

    always_comb begin
        nx     = cs;
        res_d  = res_q;
        res_we = 1'b0;
        load   = 1'b0;
        step   = 1'b0;
        go_req = 1'b0;
        abort  = 1'b0;
        start  = 1'b0;

        if (wr_en) begin
            case (wr_sel)
                2'd0: begin
                    nx.en   = wr_data[0];
                    nx.chan = wr_data[CH_W+1:2];
                    go_req  = wr_data[0] & wr_data[1];
                    abort   = ~wr_data[0];
                end
                2'd1: begin
                    nx.div = wr_data[2:0];
                    nx.acq = wr_data[5:3];
                    nx.pos = wr_data[6];
                    nx.neg = wr_data[7];
                end
                2'd3: if (!wr_data[7]) nx.irq = 1'b0;
                default: ;
            endcase
        end

        if (abort) begin
            nx.go     = 1'b0;
            nx.state  = ST_IDLE;
            nx.wait_n = '0;
        end else begin
            case (cs.state)
                ST_IDLE: if (go_req) begin
                    nx.go = 1'b1;
                    start = 1'b1;
                end
                ST_ACQ: if (tick) begin
                    if (cs.wait_n == '0) begin
                        nx.state = ST_CONV;
                        load     = 1'b1;
                    end else begin
                        nx.wait_n = cs.wait_n - 1'b1;
                    end
                end
                ST_CONV: if (tick) begin
                    step = 1'b1;
                    if (last) begin
                        res_d     = final_code;
                        res_we    = 1'b1;
                        nx.go     = 1'b0;
                        nx.irq    = 1'b1;
                        nx.state  = ST_GAP;
                        nx.wait_n = WAIT_W'(GAP_TAD - 1);
                    end
                end
                default: begin
                    if (go_req) nx.go = 1'b1;
                    if (tick) begin
                        if (cs.wait_n != '0)  nx.wait_n = cs.wait_n - 1'b1;
                        else if (nx.go)       start = 1'b1;
                        else                  nx.state = ST_IDLE;
                    end
                end
            endcase
        end

        if (start) begin
            nx.state  = ST_ACQ;
            nx.wait_n = WAIT_W'(acq_tads(nx.acq));
            nx.chan_a = nx.chan;
            nx.div_a  = nx.div;
            nx.pos_a  = nx.pos;
            nx.neg_a  = nx.neg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs <= '0;
        else        cs <= nx;
    end

    // result pair keeps its value across reset
    always_ff @(posedge clk) begin
        if (rst_n && res_we) res_q <= res_d;
    end

    always_comb begin
        case (rd_sel)
            2'd0:    rd_data = 8'({cs.chan, cs.go, cs.en});
            2'd1:    rd_data = {cs.neg, cs.pos, cs.acq, cs.div};
            2'd2:    rd_data = res_q[7:0];
            default: rd_data = {cs.irq, {(7-HI_W){1'b0}}, res_q[RES_W-1:8]};
        endcase
    end

    assign irq_o        = cs.irq;
    assign mux_sel      = cs.chan_a;
    assign vref_pos_ext = cs.pos_a;
    assign vref_neg_ext = cs.neg_a;
    assign hold_o       = (cs.state == ST_CONV);
    assign trial_code   = hold_o ? trial : '0;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int RES_W = 10,
    parameter int CH_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_q,
    input logic             go_q,
    input logic             irq,
    input logic             hold,
    input logic [CH_W-1:0]  mux_sel,
    input logic [RES_W-1:0] trial_code,
    input logic [RES_W-1:0] result
);
    // R9
    go_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go_q) |-> en_q);

    // R6
    done_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(go_q) && en_q && $past(hold)) |-> (irq && !hold));

    // R11
    result_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> ($fell(go_q) && en_q));

    // R10
    chan_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold)) |-> $stable(mux_sel));

    // R13
    trial_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (trial_code != '0));

    // R13
    hold_under_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> go_q);
endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W), .CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_q       (cs.en),
    .go_q       (cs.go),
    .irq        (cs.irq),
    .hold       (hold_o),
    .mux_sel    (mux_sel),
    .trial_code (trial_code),
    .result     (res_q)
);

// File: tb/sim_sar_seq.sv
module sim_sar_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic       cmp_in, irq_o, vref_pos_ext, vref_neg_ext, hold_o;
    logic [3:0] mux_sel;
    logic [9:0] trial_code;
    logic [9:0] vin [16];

    int vectors = 0;
    int fails   = 0;

    always #2 clk = ~clk;

    sar_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .cmp_in(cmp_in), .irq_o(irq_o),
        .mux_sel(mux_sel), .vref_pos_ext(vref_pos_ext), .vref_neg_ext(vref_neg_ext),
        .hold_o(hold_o), .trial_code(trial_code)
    );

    // external comparator: analog value of the selected input vs DAC code
    assign cmp_in = (vin[mux_sel] >= trial_code);

    // behavioural reference model
    int m_en, m_go, m_irq, m_chan, m_div, m_acq, m_pos, m_neg;
    int m_phase, m_t, m_N, m_A, m_chan_a, m_pos_a, m_neg_a, m_started;
    int m_res = -1;

    function automatic int per_of(input int code);
        return (code > 5) ? 64 : (2 << code);
    endfunction

    function automatic int acq_of(input int code);
        case (code)
            0: return 0;   1: return 2;   2: return 4;   3: return 6;
            4: return 8;   5: return 12;  6: return 16;  default: return 20;
        endcase
    endfunction

    always @(posedge clk) begin
        int req, abrt, strt;
        req = 0; abrt = 0; strt = 0;
        if (!rst_n) begin
            m_en = 0; m_go = 0; m_irq = 0; m_chan = 0; m_div = 0; m_acq = 0;
            m_pos = 0; m_neg = 0; m_phase = 0; m_t = 0; m_started = 0;
            m_chan_a = 0; m_pos_a = 0; m_neg_a = 0; m_N = 2; m_A = 0;
        end else begin
            if (wr_en) begin
                case (wr_sel)
                    2'd0: begin
                        m_en = wr_data[0]; m_chan = wr_data[5:2];
                        req = wr_data[0] && wr_data[1]; abrt = !wr_data[0];
                    end
                    2'd1: begin
                        m_div = wr_data[2:0]; m_acq = wr_data[5:3];
                        m_pos = wr_data[6]; m_neg = wr_data[7];
                    end
                    2'd3: if (!wr_data[7]) m_irq = 0;
                    default: ;
                endcase
            end
            if (abrt) begin
                m_go = 0; m_phase = 0;
            end else if (m_phase == 0) begin
                if (req) begin m_go = 1; strt = 1; end
            end else if (m_phase == 1) begin
                m_t--;
                if (m_t == 0) begin
                    m_res = vin[m_chan_a]; m_go = 0; m_irq = 1;
                    m_phase = 2; m_t = 2 * m_N;
                end
            end else begin
                if (req) m_go = 1;
                m_t--;
                if (m_t == 0) begin
                    if (m_go != 0) strt = 1;
                    else m_phase = 0;
                end
            end
            if (strt) begin
                m_phase = 1; m_N = per_of(m_div); m_A = acq_of(m_acq);
                m_t = m_N * (m_A + 11); m_chan_a = m_chan;
                m_pos_a = m_pos; m_neg_a = m_neg; m_started = 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison, 1 ns after the active edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            chk("R8 irq_o", irq_o, m_irq);
            chk("R13 hold_o", hold_o, (m_phase == 1 && m_t <= 10 * m_N) ? 1 : 0);
            if (rd_sel == 2'd0) chk("R6 R9 go/enable", rd_data[1:0], m_go * 2 + m_en);
            if (m_started != 0) begin
                chk("R10 mux_sel", mux_sel, m_chan_a);
                chk("R10 vref_pos_ext", vref_pos_ext, m_pos_a);
                chk("R10 vref_neg_ext", vref_neg_ext, m_neg_a);
            end
        end
    end

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        rd_sel = s;
        #1 v = rd_data;
        rd_sel = 2'd0;
    endtask

    task automatic wait_phase(input int ph);
        for (int i = 0; i < 20000 && m_phase != ph; i++) @(negedge clk);
        if (m_phase != ph) begin
            fails++;
            $display("FAIL R5 phase wait actual=%0d expected=%0d", m_phase, ph);
        end
    endtask

    task automatic check_result(input string tag, input int exp);
        logic [7:0] lo, hi;
        rd(2'd2, lo);
        rd(2'd3, hi);
        chk(tag, {hi[1:0], lo}, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 16; i++) vin[i] = 10'(i * 61);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 R12: reset defaults
        rd(2'd0, v); chk("R1 ctrl after reset", v, 8'h00);
        rd(2'd1, v); chk("R1 cfg after reset", v, 8'h00);
        rd(2'd3, v); chk("R1 flag after reset", v[7], 0);

        // R3 R5 R6: channel 3, TAD 2 clocks, no acquisition
        vin[3] = 10'h2A5;
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h0F);
        wait_phase(0);
        check_result("R3 R12 result ch3", 10'h2A5);
        rd(2'd3, v); chk("R6 flag set", v[7], 1);

        // R8: write 1 keeps, write 0 clears
        wr(2'd3, 8'h80);
        rd(2'd3, v); chk("R8 flag kept on write 1", v[7], 1);
        wr(2'd3, 8'h00);
        rd(2'd3, v); chk("R8 flag cleared on write 0", v[7], 0);

        // R4 R5 R10: channel 15, TAD 8 clocks, 6 TAD acquisition, external positive ref
        vin[15] = 10'h3FF;
        wr(2'd1, 8'h5A);
        rd(2'd1, v); chk("R12 cfg readback", v, 8'h5A);
        wr(2'd0, 8'h3F);
        repeat (3) @(negedge clk);
        chk("R10 positive ref applied", vref_pos_ext, 1);
        chk("R10 negative ref rail", vref_neg_ext, 0);
        wait_phase(0);
        check_result("R3 full scale", 10'h3FF);

        // R4 saturating divider code 7 with longest acquisition
        vin[0] = 10'h000;
        wr(2'd1, 8'h3F);
        wr(2'd0, 8'h03);
        wait_phase(0);
        check_result("R3 R4 zero scale", 10'h000);

        // R9: go with enable low
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h02);
        repeat (4) @(negedge clk);
        rd(2'd0, v); chk("R9 go ignored", v, 8'h00);
        chk("R9 no hold", hold_o, 0);

        // R10: channel rewrite mid conversion
        vin[5] = 10'h155; vin[9] = 10'h0AA;
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h17);
        repeat (4) @(negedge clk);
        wr(2'd0, 8'h25);
        rd(2'd0, v); chk("R10 channel readback", v, 8'h27);
        chk("R10 mux unchanged", mux_sel, 5);
        wait_phase(2);
        check_result("R10 result from old channel", 10'h155);

        // R7: go during recovery gap pends
        wr(2'd0, 8'h27);
        rd(2'd0, v); chk("R7 go pending", v[1], 1);
        chk("R7 no hold in gap", hold_o, 0);
        wait_phase(1);
        wait_phase(0);
        check_result("R7 R10 result new channel", 10'h0AA);
        chk("R10 mux new channel", mux_sel, 9);

        // R11: abort by clearing enable
        wr(2'd3, 8'h00);
        vin[2] = 10'h300;
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h0B);
        repeat (30) @(negedge clk);
        wr(2'd0, 8'h08);
        repeat (8) @(negedge clk);
        rd(2'd0, v); chk("R11 go cleared", v[1], 0);
        chk("R11 no flag", irq_o, 0);
        check_result("R11 result kept", 10'h0AA);

        // R1 R2: reset mid conversion
        wr(2'd0, 8'h0B);
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(2'd0, v); chk("R1 ctrl after abort reset", v, 8'h00);
        chk("R1 idle after reset", hold_o, 0);
        check_result("R2 result survives reset", 10'h0AA);

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule